// File: doc/BRIEF.md
# Peripheral Access Rule Checker

This block stands between one bus master and the interconnect, and every request from that master passes through it. A request carries an address, a coherency attribute, a stash attribute and a per-request sub-identifier. The block joins the sub-identifier with the master's fixed identifier to form a composite device identifier. It then compares the identifier and the address against an eight-entry table of rules that software programs. The first matching rule decides what happens to the request. The rule can pass the request unchanged, block it, or send it to a substitute address. It can also replace the coherency and stash attributes.

A blocked request, or one that matches no rule, is not sent on. The block stores its identifier and address in fault registers and raises a one-cycle fault pulse. Every request that is passed on reaches the output register exactly one cycle after it is accepted. The rule table can only be changed while no request is in flight.

Top module: `acc_rule_gate`

## Requirements
- R1: After reset, out_valid and fault_pulse are low, in_ready is high, fault_devid and fault_addr are zero, and every rule is invalid.
- R2: A request accepted on a clock edge (in_valid and in_ready both high) that is forwarded appears on the outputs with out_valid high right after that same edge. This is exactly one cycle of latency.
- R3: A request that matches no valid rule is denied. It is not forwarded. fault_pulse is high for the one cycle after acceptance, and fault_devid and fault_addr take the request's identifier and address. The fault registers hold their values until the next denial.
- R4: A rule matches when both of these hold: the address equals the rule base in every bit where the size mask is 0, and the composite identifier {MASTER_ID (upper bits), in_sub (lower bits)} equals the rule's identifier value in every bit where the identifier mask is 1.
- R5: When several valid rules match, the rule with the lowest index decides the outcome.
- R6: The action field encodes 0 as deny, 1 as allow, 2 as redirect and 3 as deny.
- R7: A redirect forwards (redirect_base AND NOT size_mask) OR (address AND size_mask). An allowed request keeps its address.
- R8: If the winning rule's coherency override enable is set, its coherency value replaces in_coh, and otherwise in_coh passes through. The stash attribute is handled the same way with its own enable. out_devid is the composite identifier.
- R9: in_ready equals (NOT out_valid) OR out_ready. While out_valid is high and out_ready is low, the output fields stay unchanged.
- R10: A configuration write while in_valid or out_valid is high is ignored and leaves the table unchanged.
- R11: cfg_sel selects the field being written: 0 base, 1 size mask, 2 identifier ({mask in wdata[15:8], value in wdata[7:0]}), 3 control, 4 redirect base. In the control word, bit 0 is valid, bits 2:1 are the action, bit 3 is the coherency override enable, bits 5:4 are the coherency value, bit 6 is the stash override enable and bits 8:7 are the stash value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_sub | input | SUB_W | Per-request identifier field |
| in_addr | input | ADDR_W | Request address |
| in_coh | input | COH_W | Request coherency attribute |
| in_stash | input | ST_W | Request stash attribute |
| out_valid | output | 1 | Checked request present |
| out_ready | input | 1 | Downstream accepts |
| out_addr | output | ADDR_W | Forwarded address |
| out_devid | output | ID_W | Composite identifier |
| out_coh | output | COH_W | Forwarded coherency attribute |
| out_stash | output | ST_W | Forwarded stash attribute |
| cfg_we | input | 1 | Rule field write strobe |
| cfg_idx | input | IDX_W | Rule index |
| cfg_sel | input | 3 | Field select |
| cfg_wdata | input | ADDR_W | Field data |
| fault_pulse | output | 1 | One-cycle denial strobe |
| fault_devid | output | ID_W | Identifier of last denied request |
| fault_addr | output | ADDR_W | Address of last denied request |

## Verification
The case hardest to reach from the ports is a configuration write arriving while a request is held in the output register. The write can only be attempted there, because a new request cannot be presented in the same cycle. The bench gets there by holding out_ready low after a forwarded request and trying to invalidate the very rule that request used. It then sends a second request that the rule would still catch. Overlapping rules, with a lower-index narrow rule nested inside a wider one, combined with random backpressure, drive the priority select and the stall path together.

// File: rtl/acg_pkg.sv
package acg_pkg;
  typedef enum logic [1:0] {
    ACT_DENY  = 2'd0,
    ACT_ALLOW = 2'd1,
    ACT_REDIR = 2'd2,
    ACT_RSVD  = 2'd3
  } act_e;

  typedef enum logic [2:0] {
    SEL_BASE = 3'd0,
    SEL_MASK = 3'd1,
    SEL_ID   = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_RDIR = 3'd4
  } sel_e;

  localparam int CTL_VALID  = 0;
  localparam int CTL_ACT_LO = 1;
  localparam int CTL_COE    = 3;
  localparam int CTL_COH_LO = 4;
endpackage

// File: rtl/acg_rule_table.sv
module acg_rule_table #(
  parameter int N      = 8,
  parameter int ADDR_W = 32,
  parameter int ID_W   = 8,
  parameter int COH_W  = 2,
  parameter int ST_W   = 2,
  parameter int IDX_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         busy,
  input  logic                         cfg_we,
  input  logic [IDX_W-1:0]             cfg_idx,
  input  logic [2:0]                   cfg_sel,
  input  logic [ADDR_W-1:0]            cfg_wdata,
  output logic [N-1:0]                 r_valid,
  output logic [N-1:0][ADDR_W-1:0]     r_base,
  output logic [N-1:0][ADDR_W-1:0]     r_mask,
  output logic [N-1:0][ADDR_W-1:0]     r_rbase,
  output logic [N-1:0][ID_W-1:0]       r_idv,
  output logic [N-1:0][ID_W-1:0]       r_idm,
  output logic [N-1:0][1:0]            r_act,
  output logic [N-1:0]                 r_coe,
  output logic [N-1:0][COH_W-1:0]      r_coh,
  output logic [N-1:0]                 r_ste,
  output logic [N-1:0][ST_W-1:0]       r_st
);
  import acg_pkg::*;

  localparam int STE_B  = CTL_COH_LO + COH_W;
  localparam int ST_LO  = STE_B + 1;

  logic [N-1:0]             valid_n;
  logic [N-1:0][ADDR_W-1:0] base_n, mask_n, rbase_n;
  logic [N-1:0][ID_W-1:0]   idv_n, idm_n;
  logic [N-1:0][1:0]        act_n;
  logic [N-1:0]             coe_n, ste_n;
  logic [N-1:0][COH_W-1:0]  coh_n;
  logic [N-1:0][ST_W-1:0]   st_n;
  logic                     wr_ok;

  assign wr_ok = cfg_we && !busy;

  always_comb begin
    valid_n = r_valid;
    base_n  = r_base;
    mask_n  = r_mask;
    rbase_n = r_rbase;
    idv_n   = r_idv;
    idm_n   = r_idm;
    act_n   = r_act;
    coe_n   = r_coe;
    coh_n   = r_coh;
    ste_n   = r_ste;
    st_n    = r_st;
    for (int i = 0; i < N; i++) begin
      if (wr_ok && (cfg_idx == IDX_W'(i))) begin
        case (cfg_sel)
          SEL_BASE: base_n[i]  = cfg_wdata;
          SEL_MASK: mask_n[i]  = cfg_wdata;
          SEL_ID: begin
            idv_n[i] = cfg_wdata[ID_W-1:0];
            idm_n[i] = cfg_wdata[ID_W +: ID_W];
          end
          SEL_CTRL: begin
            valid_n[i] = cfg_wdata[CTL_VALID];
            act_n[i]   = cfg_wdata[CTL_ACT_LO +: 2];
            coe_n[i]   = cfg_wdata[CTL_COE];
            coh_n[i]   = cfg_wdata[CTL_COH_LO +: COH_W];
            ste_n[i]   = cfg_wdata[STE_B];
            st_n[i]    = cfg_wdata[ST_LO +: ST_W];
          end
          SEL_RDIR: rbase_n[i] = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid <= '0;
      r_base  <= '0;
      r_mask  <= '0;
      r_rbase <= '0;
      r_idv   <= '0;
      r_idm   <= '0;
      r_act   <= '0;
      r_coe   <= '0;
      r_coh   <= '0;
      r_ste   <= '0;
      r_st    <= '0;
    end else begin
      r_valid <= valid_n;
      r_base  <= base_n;
      r_mask  <= mask_n;
      r_rbase <= rbase_n;
      r_idv   <= idv_n;
      r_idm   <= idm_n;
      r_act   <= act_n;
      r_coe   <= coe_n;
      r_coh   <= coh_n;
      r_ste   <= ste_n;
      r_st    <= st_n;
    end
  end

  // R10
  cfg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy) |=> ($stable(r_valid) && $stable(r_base) && $stable(r_mask)
                         && $stable(r_act) && $stable(r_rbase)));
endmodule

// File: rtl/acg_matcher.sv
module acg_matcher #(
  parameter int N      = 8,
  parameter int ADDR_W = 32,
  parameter int ID_W   = 8,
  parameter int COH_W  = 2,
  parameter int ST_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            in_addr,
  input  logic [ID_W-1:0]              in_id,
  input  logic [COH_W-1:0]             in_coh,
  input  logic [ST_W-1:0]              in_st,
  input  logic [N-1:0]                 r_valid,
  input  logic [N-1:0][ADDR_W-1:0]     r_base,
  input  logic [N-1:0][ADDR_W-1:0]     r_mask,
  input  logic [N-1:0][ADDR_W-1:0]     r_rbase,
  input  logic [N-1:0][ID_W-1:0]       r_idv,
  input  logic [N-1:0][ID_W-1:0]       r_idm,
  input  logic [N-1:0][1:0]            r_act,
  input  logic [N-1:0]                 r_coe,
  input  logic [N-1:0][COH_W-1:0]      r_coh,
  input  logic [N-1:0]                 r_ste,
  input  logic [N-1:0][ST_W-1:0]       r_st,
  output logic                         fwd,
  output logic [ADDR_W-1:0]            n_addr,
  output logic [COH_W-1:0]             n_coh,
  output logic [ST_W-1:0]              n_st
);
  import acg_pkg::*;

  logic [N-1:0]        hit;
  logic [N-1:0]        grant;
  logic [ADDR_W-1:0]   s_mask, s_rbase;
  logic [1:0]          s_act;
  logic                s_coe, s_ste;
  logic [COH_W-1:0]    s_coh;
  logic [ST_W-1:0]     s_st;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = r_valid[g]
                  && (((in_addr ^ r_base[g]) & ~r_mask[g]) == '0)
                  && (((in_id ^ r_idv[g]) & r_idm[g]) == '0);
  end

  assign grant = hit & (~hit + N'(1));

  always_comb begin
    s_mask  = '0;
    s_rbase = '0;
    s_act   = '0;
    s_coe   = 1'b0;
    s_coh   = '0;
    s_ste   = 1'b0;
    s_st    = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        s_mask  = s_mask  | r_mask[i];
        s_rbase = s_rbase | r_rbase[i];
        s_act   = s_act   | r_act[i];
        s_coe   = s_coe   | r_coe[i];
        s_coh   = s_coh   | r_coh[i];
        s_ste   = s_ste   | r_ste[i];
        s_st    = s_st    | r_st[i];
      end
    end
  end

  always_comb begin
    fwd    = (|grant) && ((s_act == ACT_ALLOW) || (s_act == ACT_REDIR));
    n_addr = (s_act == ACT_REDIR) ? ((s_rbase & ~s_mask) | (in_addr & s_mask)) : in_addr;
    n_coh  = s_coe ? s_coh : in_coh;
    n_st   = s_ste ? s_st  : in_st;
  end

  // R3
  fwd_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> (|hit));
endmodule

// File: rtl/acg_out_stage.sv
module acg_out_stage #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 8,
  parameter int COH_W  = 2,
  parameter int ST_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              out_ready,
  input  logic              fwd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] n_addr,
  input  logic [COH_W-1:0]  n_coh,
  input  logic [ST_W-1:0]   n_st,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ID_W-1:0]   out_devid,
  output logic [COH_W-1:0]  out_coh,
  output logic [ST_W-1:0]   out_stash,
  output logic              fault_pulse,
  output logic [ID_W-1:0]   fault_devid,
  output logic [ADDR_W-1:0] fault_addr
);
  logic accept, load_en, fault_en;
  logic ov_n, fp_n;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign load_en  = accept && fwd;
  assign fault_en = accept && !fwd;

  always_comb begin
    if (accept)         ov_n = fwd;
    else if (out_ready) ov_n = 1'b0;
    else                ov_n = out_valid;
    fp_n = fault_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      fault_pulse <= 1'b0;
    end else begin
      out_valid   <= ov_n;
      fault_pulse <= fp_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr  <= '0;
      out_devid <= '0;
      out_coh   <= '0;
      out_stash <= '0;
    end else if (load_en) begin
      out_addr  <= n_addr;
      out_devid <= req_id;
      out_coh   <= n_coh;
      out_stash <= n_st;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_devid <= '0;
      fault_addr  <= '0;
    end else if (fault_en) begin
      fault_devid <= req_id;
      fault_addr  <= req_addr;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_devid)));
  // R3
  deny_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !fwd) |=> (!out_valid && fault_pulse));
  // R2
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && fwd) |=> out_valid);
endmodule

// File: rtl/acc_rule_gate.sv
module acc_rule_gate #(
  parameter int               N         = 8,
  parameter int               ADDR_W    = 32,
  parameter int               MST_W     = 4,
  parameter int               SUB_W     = 4,
  parameter int               COH_W     = 2,
  parameter int               ST_W      = 2,
  parameter logic [MST_W-1:0] MASTER_ID = 4'h5,
  localparam int              ID_W      = MST_W + SUB_W,
  localparam int              IDX_W     = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SUB_W-1:0]  in_sub,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [COH_W-1:0]  in_coh,
  input  logic [ST_W-1:0]   in_stash,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ID_W-1:0]   out_devid,
  output logic [COH_W-1:0]  out_coh,
  output logic [ST_W-1:0]   out_stash,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              fault_pulse,
  output logic [ID_W-1:0]   fault_devid,
  output logic [ADDR_W-1:0] fault_addr
);
  logic [N-1:0]             r_valid, r_coe, r_ste;
  logic [N-1:0][ADDR_W-1:0] r_base, r_mask, r_rbase;
  logic [N-1:0][ID_W-1:0]   r_idv, r_idm;
  logic [N-1:0][1:0]        r_act;
  logic [N-1:0][COH_W-1:0]  r_coh;
  logic [N-1:0][ST_W-1:0]   r_st;
  logic [ID_W-1:0]          req_id;
  logic                     fwd, busy;
  logic [ADDR_W-1:0]        n_addr;
  logic [COH_W-1:0]         n_coh;
  logic [ST_W-1:0]          n_st;

  assign req_id = {MASTER_ID, in_sub};
  assign busy   = in_valid || out_valid;

  acg_rule_table #(.N(N), .ADDR_W(ADDR_W), .ID_W(ID_W), .COH_W(COH_W),
                   .ST_W(ST_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .r_valid(r_valid), .r_base(r_base), .r_mask(r_mask), .r_rbase(r_rbase),
    .r_idv(r_idv), .r_idm(r_idm), .r_act(r_act), .r_coe(r_coe), .r_coh(r_coh),
    .r_ste(r_ste), .r_st(r_st)
  );

  acg_matcher #(.N(N), .ADDR_W(ADDR_W), .ID_W(ID_W), .COH_W(COH_W),
                .ST_W(ST_W)) u_match (
    .clk(clk), .rst_n(rst_n), .in_addr(in_addr), .in_id(req_id),
    .in_coh(in_coh), .in_st(in_stash),
    .r_valid(r_valid), .r_base(r_base), .r_mask(r_mask), .r_rbase(r_rbase),
    .r_idv(r_idv), .r_idm(r_idm), .r_act(r_act), .r_coe(r_coe), .r_coh(r_coh),
    .r_ste(r_ste), .r_st(r_st),
    .fwd(fwd), .n_addr(n_addr), .n_coh(n_coh), .n_st(n_st)
  );

  acg_out_stage #(.ADDR_W(ADDR_W), .ID_W(ID_W), .COH_W(COH_W),
                  .ST_W(ST_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_ready(out_ready), .fwd(fwd), .req_addr(in_addr), .req_id(req_id),
    .n_addr(n_addr), .n_coh(n_coh), .n_st(n_st),
    .out_valid(out_valid), .out_addr(out_addr), .out_devid(out_devid),
    .out_coh(out_coh), .out_stash(out_stash),
    .fault_pulse(fault_pulse), .fault_devid(fault_devid), .fault_addr(fault_addr)
  );
endmodule

// File: tb/acc_rule_gate_bench.sv
module acc_rule_gate_bench;
  localparam logic [3:0] MID = 4'h5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, out_ready, cfg_we;
  logic [3:0]  in_sub;
  logic [31:0] in_addr, cfg_wdata;
  logic [1:0]  in_coh, in_stash;
  logic [2:0]  cfg_idx, cfg_sel;
  logic        in_ready, out_valid, fault_pulse;
  logic [31:0] out_addr, fault_addr;
  logic [7:0]  out_devid, fault_devid;
  logic [1:0]  out_coh, out_stash;

  always #4 clk = ~clk;

  acc_rule_gate #(.MASTER_ID(MID)) u_acc_rule_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sub(in_sub), .in_addr(in_addr), .in_coh(in_coh), .in_stash(in_stash),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_devid(out_devid), .out_coh(out_coh), .out_stash(out_stash),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fault_pulse(fault_pulse), .fault_devid(fault_devid), .fault_addr(fault_addr)
  );

  // reference model state
  logic        rv[8];
  logic [31:0] rb[8], rm[8], rr[8];
  logic [7:0]  riv[8], rim[8];
  logic [8:0]  rc[8];
  logic        m_ov, m_fp, m_acc, bp;
  logic [31:0] m_addr, m_faddr;
  logic [7:0]  m_id, m_fid;
  logic [1:0]  m_coh, m_st;
  int          checks = 0, fails = 0;
  string       cur_req = "R1";

  task automatic check_outputs();
    logic [63:0] act, exp;
    checks++;
    act = {31'd0, in_ready, out_valid, fault_pulse, fault_devid, fault_addr};
    exp = {31'd0, (!m_ov || out_ready), m_ov, m_fp, m_fid, m_faddr};
    if (act != exp) begin
      fails++;
      $display("FAIL %s ctl/fault actual=%h expected=%h", cur_req, act, exp);
    end
    if (m_ov) begin
      checks++;
      act = {20'd0, out_coh, out_stash, out_devid, out_addr};
      exp = {20'd0, m_coh, m_st, m_id, m_addr};
      if (act != exp) begin
        fails++;
        $display("FAIL %s payload actual=%h expected=%h", cur_req, act, exp);
      end
    end
  endtask

  task automatic tick();
    logic [7:0] id;
    logic       found, fw;
    int         w;
    @(posedge clk);
    m_acc = in_valid && (!m_ov || out_ready);
    if (m_acc) begin
      id = {MID, in_sub};
      found = 1'b0; w = 0;
      for (int i = 0; i < 8; i++)
        if (!found && rv[i] && (((in_addr ^ rb[i]) & ~rm[i]) == 0)
            && (((id ^ riv[i]) & rim[i]) == 0)) begin
          found = 1'b1; w = i;
        end
      fw = found && (rc[w][2:1] == 2'd1 || rc[w][2:1] == 2'd2);
      m_fp = !fw;
      if (fw) begin
        m_ov   = 1'b1;
        m_id   = id;
        m_addr = (rc[w][2:1] == 2'd2) ? ((rr[w] & ~rm[w]) | (in_addr & rm[w])) : in_addr;
        m_coh  = rc[w][3] ? rc[w][5:4] : in_coh;
        m_st   = rc[w][6] ? rc[w][8:7] : in_stash;
      end else begin
        m_ov = 1'b0; m_fid = id; m_faddr = in_addr;
      end
    end else begin
      m_fp = 1'b0;
      if (out_ready) m_ov = 1'b0;
    end
    if (cfg_we && !in_valid && !(m_ov && !m_acc && !out_ready) && !m_busy_pre) begin
      case (cfg_sel)
        3'd0: rb[cfg_idx] = cfg_wdata;
        3'd1: rm[cfg_idx] = cfg_wdata;
        3'd2: begin riv[cfg_idx] = cfg_wdata[7:0]; rim[cfg_idx] = cfg_wdata[15:8]; end
        3'd3: begin rc[cfg_idx] = cfg_wdata[8:0]; rv[cfg_idx] = cfg_wdata[0]; end
        3'd4: rr[cfg_idx] = cfg_wdata;
        default: ;
      endcase
    end
    m_busy_pre = m_ov;
    @(negedge clk);
    check_outputs();
    if (bp) out_ready = 1'($urandom_range(0, 1));
  endtask

  logic m_busy_pre;

  task automatic cfg_write(input int idx, input int sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_sel = 3'(sel); cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [3:0] sub, input logic [31:0] a,
                      input logic [1:0] c, input logic [1:0] s);
    in_valid = 1'b1; in_sub = sub; in_addr = a; in_coh = c; in_stash = s;
    do tick(); while (!m_acc);
    in_valid = 1'b0;
  endtask

  task automatic program_rule(input int idx, input logic [31:0] b, input logic [31:0] m,
                              input logic [15:0] idw, input logic [8:0] ctl,
                              input logic [31:0] r);
    cfg_write(idx, 0, b);
    cfg_write(idx, 1, m);
    cfg_write(idx, 2, {16'd0, idw});
    cfg_write(idx, 4, r);
    cfg_write(idx, 3, {23'd0, ctl});
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      rv[i] = 0; rb[i] = 0; rm[i] = 0; rr[i] = 0; riv[i] = 0; rim[i] = 0; rc[i] = 0;
    end
    m_ov = 0; m_fp = 0; m_acc = 0; m_addr = 0; m_id = 0; m_coh = 0; m_st = 0;
    m_faddr = 0; m_fid = 0; bp = 0; m_busy_pre = 0;
    rst_n = 0; in_valid = 0; out_ready = 1; cfg_we = 0; in_sub = 0; in_addr = 0;
    in_coh = 0; in_stash = 0; cfg_idx = 0; cfg_sel = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1"; check_outputs();

    // R3: empty table denies everything
    cur_req = "R3";
    send(4'h2, 32'h1000_0010, 2'd0, 2'd0);
    tick();

    // R11 field encoding used to build the rule set
    cur_req = "R11";
    // r0: narrow allow for sub 2, coherency forced to 3
    program_rule(0, 32'h1000_0000, 32'h0000_0FFF, {8'hFF, MID, 4'h2}, 9'b0_00_1_11_01_1, 32'h0);
    // r1: wide redirect for sub 0..15, stash forced to 2
    program_rule(1, 32'h1000_0000, 32'h00FF_FFFF, {8'hF0, MID, 4'h0}, 9'b10_1_00_0_10_1, 32'h8000_0000);
    // r2: explicit deny region
    program_rule(2, 32'h2000_0000, 32'h0FFF_FFFF, 16'h0000, 9'b0_00_0_00_00_1, 32'h0);
    // r3: reserved action code region
    program_rule(3, 32'h4000_0000, 32'h000F_FFFF, 16'h0000, 9'b0_00_0_00_11_1, 32'h0);
    // r7: plain allow region
    program_rule(7, 32'h3000_0000, 32'h0FFF_FFFF, 16'h0000, 9'b0_00_0_00_01_1, 32'h0);

    cur_req = "R5"; send(4'h2, 32'h1000_0123, 2'd0, 2'd1); tick();
    cur_req = "R7"; send(4'h3, 32'h1000_0123, 2'd1, 2'd1); tick();
    cur_req = "R4"; send(4'h2, 32'h1000_1123, 2'd1, 2'd0); tick();
    cur_req = "R6"; send(4'h1, 32'h2345_0000, 2'd1, 2'd0); tick();
    cur_req = "R6"; send(4'h1, 32'h4001_0000, 2'd1, 2'd0); tick();
    cur_req = "R8"; send(4'h9, 32'h3ABC_0004, 2'd2, 2'd3); tick();
    cur_req = "R3"; send(4'h9, 32'h5000_0000, 2'd2, 2'd3); tick();
    cur_req = "R2"; send(4'h4, 32'h3000_0008, 2'd0, 2'd0);
    send(4'h4, 32'h3000_000C, 2'd0, 2'd0); tick();

    // R10: write attempt while the output register is held
    cur_req = "R10";
    out_ready = 1'b0;
    send(4'h2, 32'h1000_0040, 2'd0, 2'd0);
    cfg_write(0, 3, 32'h0);
    cfg_write(0, 3, 32'h0);
    out_ready = 1'b1;
    tick();
    send(4'h2, 32'h1000_0044, 2'd0, 2'd0); tick();

    // R9: random stream under random backpressure
    cur_req = "R9";
    bp = 1'b1;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a;
      case ($urandom_range(0, 4))
        0: a = 32'h1000_0000 | ($urandom & 32'h0000_1FFF);
        1: a = 32'h1000_0000 | ($urandom & 32'h00FF_FFFF);
        2: a = 32'h2000_0000 | ($urandom & 32'h0FFF_FFFF);
        3: a = 32'h3000_0000 | ($urandom & 32'h0FFF_FFFF);
        default: a = $urandom;
      endcase
      send(4'($urandom), a, 2'($urandom), 2'($urandom));
      if ($urandom_range(0, 2) == 0) tick();
    end
    bp = 1'b0; out_ready = 1'b1;
    repeat (3) tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule